// File: doc/BRIEF.md
# Bit-Serial Unsigned Adder

This block adds two unsigned operands of `W` bits by handling one bit position per clock, least significant bit first. A single full adder and a one-bit carry register do the arithmetic. Two operand shift registers present the bits to the adder in turn, and a third register collects the sum bits. A one-cycle (or longer) `load` pulse captures both operands in parallel and clears the carry. It also presets a down-counter to `W`.

After `load` falls, the counter steps down once per clock. The sum register shifts while the counter is non-zero. After exactly `W` clocks it stops and holds the complete result, and `done` rises. `done` stays high until the next `load`. Raising `load` again, even in the middle of a run, drops the current run and starts over with the new operands. Any carry out of the top bit is discarded, so the result is `(a + b) mod 2^W`.

Top module: `bitser_adder`

## Requirements
- R1: While `load` is high, each rising edge copies `op_a` and `op_b` into the operand registers. While `load` is low, changes on `op_a` and `op_b` have no effect on `sum` or `done`.
- R2: The carry register is cleared to 0 on every edge where `load` is high. On every other edge it takes the carry-out of the full adder.
- R3: While `load` is low, both operand registers shift right by one bit per clock, and a 0 enters at the most significant bit.
- R4: While `load` is high, the step counter is set to `W`. Otherwise it decrements by one per clock until it reaches 0, and it then stays at 0.
- R5: After `load` falls, `sum` shifts right exactly `W` times, taking the adder's sum bit in at the most significant bit. It then holds `(op_a + op_b) mod 2^W` and stays unchanged until the next `load`.
- R6: `done` is high exactly when the counter is 0 and `load` is low. It is therefore low while `load` is high and during the `W` clocks of a run, high from the end of the run onward, and held until the next `load`.
- R7: A `load` that arrives during a run restarts the sequence. `W` clocks after that `load` falls, `sum` holds the result for the newly loaded operands only.
- R8: When `rst_n` is low, the counter, carry, operand registers and `sum` are all cleared. After reset, with `load` low, `done` reads 1 and `sum` reads 0.
- R9: A carry out of bit `W-1` is dropped. For example, with `W`=8, 8'hFF + 8'h01 gives 8'h00, and 8'hFF + 8'hFF gives 8'hFE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Capture operands, clear carry and restart the run |
| op_a | input | W | First addend |
| op_b | input | W | Second addend |
| sum | output | W | Sum register (final once `done` is high) |
| done | output | 1 | High when no run is active and `load` is low |

## Verification
The two functions that can fall in the same cycle are the capture of new operands and an active shift of the sum register. This happens when `load` is raised while the counter is still non-zero, so the sum register is still shifting in the same cycle that fresh operands arrive. The bench provokes this by starting one addition and raising `load` with different operands a few clocks into the run. The result is judged at the ports: `done` must stay low for the full `W` clocks after the second `load` falls, and `sum` must then equal the second pair's sum, with nothing left over from the aborted run.

// File: rtl/bitser_adder.sv
module bitser_adder #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] sum,
  output logic         done
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  qa, qb;
  logic          carry;
  logic [CW-1:0] cnt;
  logic          run, s_bit, c_out;

  assign s_bit = qa[0] ^ qb[0] ^ carry;
  assign c_out = (qa[0] & qb[0]) | (carry & (qa[0] ^ qb[0]));
  assign run   = |cnt;
  assign done  = !run && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qa    <= '0;
      qb    <= '0;
      carry <= 1'b0;
    end else if (load) begin
      qa    <= op_a;
      qb    <= op_b;
      carry <= 1'b0;
    end else begin
      qa    <= {1'b0, qa[W-1:1]};
      qb    <= {1'b0, qb[W-1:1]};
      carry <= c_out;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (load) cnt <= CW'(W);
    else if (run)  cnt <= cnt - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sum <= '0;
    else if (run) sum <= {s_bit, sum[W-1:1]};
  end
endmodule

// File: rtl/bitser_adder_chk.sv
module bitser_adder_chk #(
  parameter int W = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       load,
  input logic [W-1:0]               op_a,
  input logic [W-1:0]               qa,
  input logic                       carry,
  input logic [$clog2(W+1)-1:0]     cnt,
  input logic [W-1:0]               sum,
  input logic                       done
);
  localparam int CW = $clog2(W + 1);

  // R1
  capture_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> qa == $past(op_a));

  // R2
  carry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> carry == 1'b0);

  // R3
  shift_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> qa[W-1] == 1'b0);

  // R4
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> cnt == $past(cnt) - CW'(1));

  // R4
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(W));

  // R5
  sum_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |=> $stable(sum));

  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done || load));

  // R6
  done_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !done);
endmodule

bind bitser_adder bitser_adder_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .op_a(op_a), .qa(qa),
  .carry(carry), .cnt(cnt), .sum(sum), .done(done)
);

// File: tb/tb_bitser_adder.sv
module tb_bitser_adder;
  localparam int W = 8;
  localparam int NV = 8;
  localparam logic [2*W-1:0] VEC [NV] = '{
    {8'h02, 8'h07}, {8'h00, 8'h00}, {8'hFF, 8'h01}, {8'hFF, 8'hFF},
    {8'h55, 8'hAA}, {8'h3C, 8'h0F}, {8'h80, 8'h80}, {8'h7E, 8'h13}
  };

  logic clk = 0, rst_n = 0, load = 0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic [W-1:0] sum;
  logic done;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  bitser_adder #(.W(W)) dut (.clk(clk), .rst_n(rst_n), .load(load),
    .op_a(op_a), .op_b(op_b), .sum(sum), .done(done));

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic start(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk); load = 1; op_a = a; op_b = b;
    #1 chk(done == 1'b0, "R6 done low during load", W'(done), '0);
    @(negedge clk); load = 0;
  endtask

  // after start: W clocks, scrambling inputs (R1), checking done (R6) and result (R5)
  task automatic finish(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    logic [W-1:0] expv = a + b;
    for (int i = 1; i <= W; i++) begin
      op_a = W'(i * 37); op_b = W'(i * 91);
      @(negedge clk);
      if (i < W) chk(done == 1'b0, "R6 done low during run", W'(done), '0);
    end
    chk(done == 1'b1, "R6 done at end of run", W'(done), 1);
    chk(sum == expv, req, sum, expv);
    repeat (3) @(negedge clk);
    chk(sum == expv, "R5 sum frozen after run", sum, expv);
    chk(done == 1'b1, "R6 done held", W'(done), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(done == 1'b1, "R8 reset done", W'(done), 1);
    chk(sum == '0, "R8 reset sum", sum, '0);

    for (int v = 0; v < NV; v++) begin
      start(VEC[v][2*W-1:W], VEC[v][W-1:0]);
      finish(VEC[v][2*W-1:W], VEC[v][W-1:0], "R5 R1 R2 R3 R4 vector sum");
    end

    start(8'hFF, 8'h01);
    finish(8'hFF, 8'h01, "R9 carry out dropped");

    // R7: restart mid-run
    start(8'h11, 8'h22);
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R7 mid-run done low", W'(done), '0);
    start(8'hC3, 8'h5A);
    finish(8'hC3, 8'h5A, "R7 restart result");

    // R4: multi-cycle load keeps counter at W
    @(negedge clk); load = 1; op_a = 8'h09; op_b = 8'h0A;
    repeat (3) @(negedge clk);
    load = 0;
    finish(8'h09, 8'h0A, "R4 long load");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule